// File: doc/BRIEF.md
# Emulated Trigger Start Generator

This block decides, cycle by cycle on a 40 MHz bunch-crossing clock, when an emulated trigger may be released. It drives a one-clock start pulse to the downstream sequencer that builds and serialises the trigger itself. Software picks how the pulses are spaced. They can come at a fixed programmed spacing, at pseudo-random intervals around a programmed mean, while an external pulser is high, on each rising pulser edge, or only on a software command.

A single spacing value serves as the period in the fixed-spacing mode and as the mean in the random mode. The random mode advances a 32-bit linear feedback shift register and fires when its value, scaled by the mean, stays below 2^32. Each cycle therefore fires with probability close to 1/mean, which gives geometrically distributed gaps. The asynchronous pulser input is synchronised before it is used. The output is registered, so every source reaches `start_o` one clock after its qualifying condition.

Top module: `trig_start_gen`

## Requirements
- R1: While `rst_n` is low, and after its release while `enable` is low, `start_o` is 0.
- R2: When `enable` is low in a cycle, `start_o` is 0 in the following cycle, whatever the mode.
- R3: With `mode_sel` = 0 (fixed spacing) and spacing value P >= 1, the first pulse comes P cycles after the generator starts counting, and later pulses follow every P cycles.
- R4: In fixed-spacing mode a spacing value of 0 behaves exactly like 1, giving a pulse in every cycle.
- R5: The spacing counter restarts from the full spacing value whenever `enable` is low or `mode_sel` is not 0. After such a cycle the next pulse is therefore P cycles away.
- R6: With `mode_sel` = 1 (random) and mean M, pulses occur on average once every M cycles. A mean of 0 or 1 gives a pulse in every cycle.
- R7: With `mode_sel` = 2 (pulser level), `start_o` is high in every cycle for which the two-flop-synchronised pulser is high. The latency is three clock edges from the input change.
- R8: With `mode_sel` = 3 (pulser edge), each rising edge of the synchronised pulser gives exactly one single-cycle pulse, three edges after the input rises.
- R9: With `mode_sel` = 4 (software only), each cycle with `soft_strobe` high gives a pulse in the next cycle, and the pulser input has no effect.
- R10: `mode_sel` codes 5 to 7 produce no pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz bunch-crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Generator enable |
| mode_sel | input | 3 | Spacing mode: 0 fixed, 1 random, 2 pulser level, 3 pulser edge, 4 software |
| spacing_val | input | PW (16) | Period in cycles (mode 0) or mean in cycles (mode 1) |
| pulser_in | input | 1 | Asynchronous external pulser |
| soft_strobe | input | 1 | Software trigger command, one cycle per trigger |
| start_o | output | 1 | Single-cycle start qualifier |

## Verification
On every cycle, the assertions check the following:
- There is no output in the cycle after `enable` is low, or after an unused mode code.
- In software mode, any pulse is preceded by a strobe.
- In pulser-edge mode, no pulse is followed directly by a second pulse.
- In fixed-spacing mode, no two pulses are adjacent while a spacing of two or more is held.

Several properties can only be shown by the directed scenarios:
- the exact positions of the pulses in fixed-spacing mode, and the counter restart after disable and after a mode switch;
- the three-edge pulser latency and the count of pulses per pulser edge;
- the pulse rate in random mode, which is statistical.

// File: rtl/tsg_pkg.sv
package tsg_pkg;

  typedef enum logic [2:0] {
    MODE_FIXED  = 3'd0,
    MODE_RANDOM = 3'd1,
    MODE_LEVEL  = 3'd2,
    MODE_EDGE   = 3'd3,
    MODE_SOFT   = 3'd4
  } tsg_mode_e;

endpackage

// File: rtl/tsg_sync_edge.sv
module tsg_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level_o,
  output logic rise_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              prev_q;

  always_comb begin
    chain_d[0] = async_in;
    for (int i = 1; i < STAGES; i++) begin
      chain_d[i] = chain_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/tsg_period_cnt.sv
module tsg_period_cnt #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [PW-1:0] spacing,
  output logic          fire
);

  localparam logic [PW-1:0] ONE = PW'(1);

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] cnt_d;
  logic [PW-1:0] span;
  logic          at_end;

  always_comb begin
    span   = (spacing == '0) ? ONE : spacing;
    at_end = (cnt_q <= ONE);
    if (!run) begin
      cnt_d = span;
    end else if (at_end) begin
      cnt_d = span;
    end else begin
      cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '1;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign fire = run & at_end;

endmodule

// File: rtl/tsg_rand_gate.sv
module tsg_rand_gate #(
  parameter int              LW   = 32,
  parameter int              MW   = 16,
  parameter logic [LW-1:0]   TAPS = 32'h8020_0003,
  parameter logic [LW-1:0]   SEED = 32'h1D87_2B41
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [MW-1:0] mean,
  output logic          hit
);

  localparam int              PRW   = LW + MW;
  localparam logic [PRW-1:0]  LIMIT = PRW'(1) << LW;

  logic [LW-1:0]  lfsr_q;
  logic [LW-1:0]  lfsr_d;
  logic [MW-1:0]  mean_eff;
  logic [PRW-1:0] scaled;

  always_comb begin
    lfsr_d = {1'b0, lfsr_q[LW-1:1]} ^ (lfsr_q[0] ? TAPS : '0);
    mean_eff = (mean == '0) ? MW'(1) : mean;
    scaled   = {{MW{1'b0}}, lfsr_q} * {{LW{1'b0}}, mean_eff};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q <= SEED;
    end else if (run) begin
      lfsr_q <= lfsr_d;
    end
  end

  assign hit = run & (scaled < LIMIT);

endmodule

// File: rtl/trig_start_gen.sv
module trig_start_gen
  import tsg_pkg::*;
#(
  parameter int PW        = 16,
  parameter int SYNC_LEN  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [2:0]    mode_sel,
  input  logic [PW-1:0] spacing_val,
  input  logic          pulser_in,
  input  logic          soft_strobe,
  output logic          start_o
);

  logic      pls_level;
  logic      pls_rise;
  logic      fixed_fire;
  logic      rand_hit;
  logic      start_d;
  logic      start_q;
  tsg_mode_e mode;

  assign mode = tsg_mode_e'(mode_sel);

  tsg_sync_edge #(.STAGES(SYNC_LEN)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pulser_in),
    .level_o  (pls_level),
    .rise_o   (pls_rise)
  );

  tsg_period_cnt #(.PW(PW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (enable && (mode == MODE_FIXED)),
    .spacing (spacing_val),
    .fire    (fixed_fire)
  );

  tsg_rand_gate #(.MW(PW)) u_rand (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (enable && (mode == MODE_RANDOM)),
    .mean  (spacing_val),
    .hit   (rand_hit)
  );

  always_comb begin
    start_d = 1'b0;
    if (enable) begin
      case (mode)
        MODE_FIXED:  start_d = fixed_fire;
        MODE_RANDOM: start_d = rand_hit;
        MODE_LEVEL:  start_d = pls_level;
        MODE_EDGE:   start_d = pls_rise;
        MODE_SOFT:   start_d = soft_strobe;
        default:     start_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
    end else begin
      start_q <= start_d;
    end
  end

  assign start_o = start_q;

endmodule

module trig_start_gen_chk #(
  parameter int PW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic [2:0]    mode_sel,
  input logic [PW-1:0] spacing_val,
  input logic          soft_strobe,
  input logic          start_o
);

  // R2
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !start_o);

  // R10
  bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel > 3'd4) |=> !start_o);

  // R9
  soft_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o && ($past(mode_sel) == 3'd4)) |-> $past(soft_strobe));

  // R8
  edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o && (mode_sel == 3'd3) && ($past(mode_sel) == 3'd3)) |=> !start_o);

  // R3
  fixed_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o && (mode_sel == 3'd0) && ($past(mode_sel) == 3'd0)
     && $stable(spacing_val) && (spacing_val > PW'(1))) |=> !start_o);

endmodule

bind trig_start_gen trig_start_gen_chk #(.PW(PW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .mode_sel    (mode_sel),
  .spacing_val (spacing_val),
  .soft_strobe (soft_strobe),
  .start_o     (start_o)
);

// File: tb/trig_start_gen_tb.sv
`timescale 1ns/1ps
module trig_start_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable;
  logic [2:0]  mode_sel;
  logic [15:0] spacing_val;
  logic        pulser_in;
  logic        soft_strobe;
  logic        start_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  trig_start_gen u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .mode_sel    (mode_sel),
    .spacing_val (spacing_val),
    .pulser_in   (pulser_in),
    .soft_strobe (soft_strobe),
    .start_o     (start_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic go_idle();
    @(negedge clk);
    enable = 1'b0; mode_sel = 3'd0; spacing_val = '0;
    pulser_in = 1'b0; soft_strobe = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic first_hit(input int limit, output int k);
    k = 0;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (start_o && k == 0) k = i;
      if (k != 0) break;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; enable = 1'b0; mode_sel = 3'd4; spacing_val = 16'd1;
    pulser_in = 1'b1; soft_strobe = 1'b1;
    repeat (3) @(negedge clk);
    chk(start_o == 1'b0, "R1 in reset", int'(start_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(start_o == 1'b0, "R1 after reset, disabled", int'(start_o), 0);
    go_idle();
  endtask

  task automatic t_fixed();
    int mism = 0;
    mode_sel = 3'd0; spacing_val = 16'd4;
    @(negedge clk);
    enable = 1'b1;
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      if (start_o != (k % 4 == 0)) mism++;
    end
    chk(mism == 0, "R3 period 4 pulse positions", mism, 0);
    go_idle();
  endtask

  task automatic t_zero_one();
    int highs;
    for (int v = 0; v <= 1; v++) begin
      highs = 0;
      mode_sel = 3'd0; spacing_val = 16'(v);
      @(negedge clk);
      enable = 1'b1;
      for (int k = 1; k <= 8; k++) begin
        @(negedge clk);
        if (start_o) highs++;
      end
      chk(highs == 8, v == 0 ? "R4 spacing 0 every cycle" : "R4 spacing 1 every cycle", highs, 8);
      go_idle();
    end
  endtask

  task automatic t_reload();
    int k;
    mode_sel = 3'd0; spacing_val = 16'd6;
    @(negedge clk);
    enable = 1'b1;
    repeat (3) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    enable = 1'b1;
    first_hit(20, k);
    chk(k == 6, "R5 restart after disable", k, 6);
    @(negedge clk);
    repeat (2) @(negedge clk);
    mode_sel = 3'd4;
    @(negedge clk);
    mode_sel = 3'd0;
    first_hit(20, k);
    chk(k == 6, "R5 restart after mode switch", k, 6);
    go_idle();
  endtask

  task automatic t_disable();
    mode_sel = 3'd0; spacing_val = 16'd1;
    @(negedge clk);
    enable = 1'b1;
    repeat (3) @(negedge clk);
    chk(start_o == 1'b1, "R2 precondition running", int'(start_o), 1);
    enable = 1'b0;
    @(negedge clk);
    chk(start_o == 1'b0, "R2 quiet one cycle after disable", int'(start_o), 0);
    go_idle();
  endtask

  task automatic t_random();
    int cnt;
    for (int v = 0; v <= 1; v++) begin
      cnt = 0;
      mode_sel = 3'd1; spacing_val = 16'(v);
      @(negedge clk);
      enable = 1'b1;
      for (int k = 1; k <= 32; k++) begin
        @(negedge clk);
        if (start_o) cnt++;
      end
      chk(cnt == 32, "R6 mean 0/1 every cycle", cnt, 32);
      go_idle();
    end
    cnt = 0;
    mode_sel = 3'd1; spacing_val = 16'd16;
    @(negedge clk);
    enable = 1'b1;
    for (int k = 1; k <= 4096; k++) begin
      @(negedge clk);
      if (start_o) cnt++;
    end
    chk(cnt >= 160 && cnt <= 400, "R6 mean 16 rate over 4096 cycles", cnt, 256);
    go_idle();
  endtask

  task automatic t_level();
    int highs = 0;
    int first = 0;
    mode_sel = 3'd2;
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    pulser_in = 1'b1;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      if (k == 5) pulser_in = 1'b0;
      if (start_o) begin
        highs++;
        if (first == 0) first = k;
      end
    end
    chk(first == 3, "R7 level latency", first, 3);
    chk(highs == 5, "R7 level high cycles", highs, 5);
    go_idle();
  endtask

  task automatic t_edge();
    int cnt = 0;
    int first = 0;
    int adj = 0;
    bit prev = 1'b0;
    mode_sel = 3'd3;
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    pulser_in = 1'b1;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      if (start_o) begin cnt++; if (first == 0) first = k; end
    end
    chk(first == 3, "R8 edge latency", first, 3);
    chk(cnt == 1, "R8 one pulse for long high", cnt, 1);
    pulser_in = 1'b0;
    repeat (4) @(negedge clk);
    cnt = 0;
    for (int p = 0; p < 3; p++) begin
      for (int k = 0; k < 5; k++) begin
        pulser_in = (k < 2);
        @(negedge clk);
        if (start_o) cnt++;
        if (start_o && prev) adj++;
        prev = start_o;
      end
    end
    pulser_in = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (start_o) cnt++;
      if (start_o && prev) adj++;
      prev = start_o;
    end
    chk(cnt == 3, "R8 three edges three pulses", cnt, 3);
    chk(adj == 0, "R8 pulses single cycle", adj, 0);
    go_idle();
  endtask

  task automatic t_soft();
    int cnt = 0;
    mode_sel = 3'd4;
    @(negedge clk);
    enable = 1'b1;
    soft_strobe = 1'b1;
    @(negedge clk);
    soft_strobe = 1'b0;
    chk(start_o == 1'b1, "R9 pulse one cycle after strobe", int'(start_o), 1);
    @(negedge clk);
    chk(start_o == 1'b0, "R9 single cycle", int'(start_o), 0);
    soft_strobe = 1'b1;
    @(negedge clk);
    chk(start_o == 1'b1, "R9 back-to-back first", int'(start_o), 1);
    @(negedge clk);
    soft_strobe = 1'b0;
    chk(start_o == 1'b1, "R9 back-to-back second", int'(start_o), 1);
    for (int k = 0; k < 12; k++) begin
      pulser_in = k[1];
      @(negedge clk);
      if (k > 0 && start_o) cnt++;
    end
    chk(cnt == 0, "R9 pulser ignored", cnt, 0);
    go_idle();
  endtask

  task automatic t_badmode();
    int cnt = 0;
    spacing_val = 16'd1;
    @(negedge clk);
    enable = 1'b1;
    for (int m = 5; m <= 7; m++) begin
      mode_sel = 3'(m);
      for (int k = 0; k < 8; k++) begin
        pulser_in = k[0];
        soft_strobe = 1'b1;
        @(negedge clk);
        if (start_o) cnt++;
      end
    end
    chk(cnt == 0, "R10 unused modes silent", cnt, 0);
    go_idle();
  endtask

  initial begin
    t_reset();
    t_fixed();
    t_zero_one();
    t_reload();
    t_disable();
    t_random();
    t_level();
    t_edge();
    t_soft();
    t_badmode();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule